// File: doc/BRIEF.md
# SMBus Slave Front End with Alert-Response Arbitration

This block is the two-wire serial front end of a dual-channel power-switch controller. It watches already-synchronized samples of the clock and data lines and recognizes start, repeated start and stop conditions. It shifts in a 7-bit address plus a direction bit and matches the address against the channel pair chosen by a select pin. A write carries exactly one byte, which is handed to the register logic with a one-cycle strobe once the transfer closes cleanly. A read returns one byte taken from an input port.

The block also answers the shared alert-response read while its alert input is pending. In that read it sends its own channel-A address followed by a 0 bit. Because the line is wired-AND, it watches every bit it leaves released. The first time it sees a 0 where it sent a 1, it withdraws for the rest of the transfer, so the lowest address on the bus wins.

The data output is a pull-down request: 1 pulls the line low and 0 releases it. Register contents, switch decoding and fault sources sit outside the block.

Top module: `smb_alert_slave`

## Requirements
- R1: A start is the data line falling while the clock is high, and a stop is the data line rising while the clock is high. A start at any point, including a repeated start, abandons the current transfer and begins a fresh address phase.
- R2: The address byte arrives most significant bit first: seven address bits, then a direction bit (1 = read, 0 = write). With `addr_sel_i`=0 the channel addresses are 1010000 (channel A) and 1010001 (channel B). With `addr_sel_i`=1 they are 1010010 (A) and 1010011 (B).
- R3: If the address does not match, the block gives no acknowledge and never pulls the line until the next start.
- R4: For a matching write address, the block pulls the line low during the ninth clock. It then shifts in 8 data bits MSB first and acknowledges them the same way.
- R5: When an acknowledged write byte is followed by a stop or a repeated start, `wr_commit_o` pulses for one cycle. In that cycle `wr_byte_o` holds the byte and `wr_chan_o` holds the channel (0 = A, 1 = B). After a repeated start, the next address is decoded normally, so a read can follow.
- R6: A stop or start that arrives before all 8 write data bits are in produces no strobe and leaves `wr_byte_o` unchanged.
- R7: A write to the alert-response address 0001100 is not acknowledged.
- R8: A read of a channel address is acknowledged. The block then sends `rd_byte_i` MSB first and releases the line for the master's acknowledge bit. After that it stays released until the next start.
- R9: A read of 0001100 is acknowledged only while `alert_pend_i`=1. The byte sent is the selected channel-A address followed by a 0 bit.
- R10: During the alert-response byte, if the block samples 0 on the clock rising edge while it is releasing the line for a 1, it stops driving for the rest of the transfer.
- R11: `sda_pull_o` changes only while the clock is low. It is updated after the clock falling edge, and data is sampled on the rising edge.
- R12: After reset, `sda_pull_o` and `wr_commit_o` are 0, and `wr_byte_o` and `wr_chan_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized sample of the serial clock line |
| sda_i | input | 1 | Synchronized sample of the serial data line (wired-AND value) |
| addr_sel_i | input | 1 | Address-select pin level |
| alert_pend_i | input | 1 | Alert pending; enables the alert-response answer |
| rd_byte_i | input | 8 | Byte returned on a channel read |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| wr_byte_o | output | 8 | Last committed write byte |
| wr_chan_o | output | 1 | Channel of the last committed byte (0 = A, 1 = B) |
| wr_commit_o | output | 1 | One-cycle strobe when a write byte is committed |

## Verification
The assertions assume the following about the inputs:
- A master changes the data line only while the clock is low, except when it forms a start or a stop.
- Each clock phase lasts several system clocks.

Under those assumptions, the pull output can only toggle in a cycle that follows a low clock sample, and a commit can only follow a data-line edge seen under a high clock. The bench master keeps to this by holding each clock phase for four cycles and moving its data two cycles into the low phase. A second bench-side open-drain slave shares the line, so that arbitration is exercised in both the losing and the winning direction.

// File: rtl/smb_slv_pkg.sv
package smb_slv_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [ADDR_W-3:0] CHAN_BASE  = 5'b10100;
    localparam logic [ADDR_W-1:0] ALERT_ADDR = 7'b0001100;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WDATA_ACK, ST_WAIT_END, ST_RDATA
    } slv_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } line_evt_t;

    typedef struct packed {
        logic hit;
        logic is_alert;
        logic chan;
    } addr_hit_t;

    function automatic logic [ADDR_W-1:0] chan_addr(input logic sel, input logic chan);
        return {CHAN_BASE, sel, chan};
    endfunction
endpackage

// File: rtl/smb_line_events.sv
module smb_line_events
    import smb_slv_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_i,
    input  logic      sda_i,
    output line_evt_t evt_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt_o.rise  = scl_i & ~scl_q;
        evt_o.fall  = ~scl_i & scl_q;
        evt_o.start = scl_i & scl_q & sda_q & ~sda_i;
        evt_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/smb_addr_decode.sv
module smb_addr_decode
    import smb_slv_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_byte_i,
    input  logic              sel_i,
    input  logic              alert_i,
    output addr_hit_t         hit_o
);
    logic [ADDR_W-1:0] a;
    logic              rd;
    logic              chan_hit, alert_hit;

    always_comb begin
        a         = addr_byte_i[BYTE_W-1:1];
        rd        = addr_byte_i[0];
        chan_hit  = (a[ADDR_W-1:1] == chan_addr(sel_i, 1'b0) >> 1);
        alert_hit = (a == ALERT_ADDR) & rd & alert_i;
        hit_o.hit      = chan_hit | alert_hit;
        hit_o.is_alert = alert_hit;
        hit_o.chan     = chan_hit & a[0];
    end
endmodule

// File: rtl/smb_alert_slave.sv
module smb_alert_slave
    import smb_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_sel_i,
    input  logic              alert_pend_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic              sda_pull_o,
    output logic [BYTE_W-1:0] wr_byte_o,
    output logic              wr_chan_o,
    output logic              wr_commit_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    line_evt_t         evt;
    addr_hit_t         hit;
    slv_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg, txbyte;
    logic              rd_q, alert_q, chan_q;

    smb_line_events u_evt (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt_o(evt)
    );

    smb_addr_decode u_dec (
        .addr_byte_i(shreg), .sel_i(addr_sel_i), .alert_i(alert_pend_i), .hit_o(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            shreg       <= '0;
            txbyte      <= '0;
            rd_q        <= 1'b0;
            alert_q     <= 1'b0;
            chan_q      <= 1'b0;
            sda_pull_o  <= 1'b0;
            wr_byte_o   <= '0;
            wr_chan_o   <= 1'b0;
            wr_commit_o <= 1'b0;
        end else begin
            wr_commit_o <= 1'b0;
            if (evt.start || evt.stop) begin
                if (state == ST_WAIT_END) begin
                    wr_commit_o <= 1'b1;
                    wr_byte_o   <= shreg;
                    wr_chan_o   <= chan_q;
                end
                sda_pull_o <= 1'b0;
                cnt        <= '0;
                state      <= evt.start ? ST_ADDR : ST_IDLE;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (evt.rise && cnt < FULL) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_i};
                            cnt   <= cnt + CNT_W'(1);
                        end else if (evt.fall && cnt == FULL) begin
                            if (state == ST_WDATA) begin
                                sda_pull_o <= 1'b1;
                                state      <= ST_WDATA_ACK;
                            end else if (hit.hit) begin
                                sda_pull_o <= 1'b1;
                                rd_q       <= shreg[0];
                                alert_q    <= hit.is_alert;
                                chan_q     <= hit.chan;
                                txbyte     <= hit.is_alert ? {chan_addr(addr_sel_i, 1'b0), 1'b0}
                                                           : rd_byte_i;
                                state      <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.fall) begin
                            cnt <= '0;
                            if (rd_q) begin
                                sda_pull_o <= ~txbyte[BYTE_W-1];
                                state      <= ST_RDATA;
                            end else begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (evt.fall) begin
                            sda_pull_o <= 1'b0;
                            state      <= ST_WAIT_END;
                        end
                    end
                    ST_RDATA: begin
                        if (evt.rise && cnt < FULL) begin
                            cnt <= cnt + CNT_W'(1);
                            if (alert_q && txbyte[BYTE_W-1] && !sda_i) begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_IDLE;
                            end
                        end else if (evt.fall) begin
                            if (cnt == FULL) begin
                                sda_pull_o <= 1'b0;
                                state      <= ST_IDLE;
                            end else begin
                                txbyte     <= {txbyte[BYTE_W-2:0], 1'b0};
                                sda_pull_o <= ~txbyte[BYTE_W-2];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the pull output only moves after a low clock sample
    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_i));

    // R5: commit is a single-cycle strobe
    assert_commit_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        wr_commit_o |=> !wr_commit_o);

    // R5, R6: commit only follows a data edge under a high clock
    assert_commit_on_cond_R6: assert property (@(posedge clk) disable iff (rst)
        wr_commit_o |-> ($past(scl_i) && ($past(sda_i) != $past(sda_i, 2))));

    // R3: an idle slave leaves the line alone
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_pull_o);

    // R4: bit counter never passes a full byte
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    // R10: leaving a read byte always releases the line
    assert_read_exit_release_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_RDATA && state == ST_IDLE) |-> !sda_pull_o);
endmodule

// File: tb/smb_alert_slave_tb.sv
module smb_alert_slave_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       m_scl = 1'b1, m_sda = 1'b1, o_pull = 1'b0;
    logic       sel = 1'b0, alert = 1'b0;
    logic [7:0] rdd = 8'h00;
    logic       drv, chan, commit;
    logic [7:0] wbyte;
    logic       sda_line;
    assign sda_line = m_sda & ~drv & ~o_pull;

    smb_alert_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .addr_sel_i(sel), .alert_pend_i(alert), .rd_byte_i(rdd),
        .sda_pull_o(drv), .wr_byte_o(wbyte), .wr_chan_o(chan), .wr_commit_o(commit)
    );

    int checks = 0, errors = 0;
    logic [8:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, input logic ob, output logic seen);
        logic d0;
        wt(2); m_sda = b; o_pull = ~ob;
        wt(2); m_scl = 1'b1;
        wt(1); d0 = drv;
        wt(2); seen = sda_line;
        chk(drv == d0, "R11 pull moved with clock high", drv, d0);
        wt(1); m_scl = 1'b0;
    endtask

    task automatic start_c();
        o_pull = 1'b0;
        m_sda = 1'b1; wt(2); m_scl = 1'b1; wt(4); m_sda = 1'b0; wt(4); m_scl = 1'b0;
    endtask

    task automatic stop_c();
        o_pull = 1'b0;
        wt(2); m_sda = 1'b0; wt(2); m_scl = 1'b1; wt(4); m_sda = 1'b1; wt(4);
    endtask

    task automatic wr_byte(input logic [7:0] b, input string tag, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(b[i], 1'b1, s);
            chk(s == b[i], tag, s, b[i]);
        end
        bit_cycle(1'b1, 1'b1, s);
        ack = ~s;
    endtask

    task automatic rd_byte(input logic [7:0] other, input logic mack, output logic [7:0] got);
        logic s, lost_o, ob;
        lost_o = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            ob = lost_o ? 1'b1 : other[i];
            bit_cycle(1'b1, ob, s);
            got[i] = s;
            if (ob && !s) lost_o = 1'b1;
        end
        bit_cycle(~mack, 1'b1, s);
    endtask

    task automatic part_bits(input int n);
        logic s;
        for (int i = 0; i < n; i++) bit_cycle(i[0], 1'b1, s);
    endtask

    always @(negedge clk) begin
        if (!rst && commit) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected commit", {chan, wbyte}, 0);
            else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({chan, wbyte} == e, "R5 commit byte/channel", {chan, wbyte}, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] got;
        wt(5); rst = 1'b0; wt(2);
        // R12 reset state
        chk(drv == 1'b0, "R12 pull after reset", drv, 0);
        chk(commit == 1'b0, "R12 commit after reset", commit, 0);
        chk({chan, wbyte} == 9'h0, "R12 byte/chan after reset", {chan, wbyte}, 0);

        // R2 R4 R5: sel=0 write channel A
        start_c(); wr_byte(8'hA0, "R4 addr bits", ack); chk(ack, "R2 R4 addr ack A sel0", ack, 1);
        wr_byte(8'h5A, "R4 data bits", ack); chk(ack, "R4 data ack", ack, 1);
        exp_q.push_back({1'b0, 8'h5A}); stop_c();
        // channel B
        start_c(); wr_byte(8'hA2, "R4 addr bits", ack); chk(ack, "R2 addr ack B sel0", ack, 1);
        wr_byte(8'hC3, "R4 data bits", ack); chk(ack, "R4 data ack B", ack, 1);
        exp_q.push_back({1'b1, 8'hC3}); stop_c();

        // R3: sel=1, old address ignored, no drive on data
        sel = 1'b1;
        start_c(); wr_byte(8'hA0, "R3 line untouched", ack); chk(!ack, "R3 R2 no ack on mismatch", ack, 0);
        wr_byte(8'hFF, "R3 line untouched", ack); chk(!ack, "R3 data not acked", ack, 0);
        stop_c(); wt(4); chk(exp_q.size() == 0, "R3 no commit", exp_q.size(), 0);

        // R5 repeated start then R8 read
        rdd = 8'h96;
        start_c(); wr_byte(8'hA6, "R4 addr bits", ack); chk(ack, "R2 addr ack B sel1", ack, 1);
        wr_byte(8'h3C, "R4 data bits", ack); chk(ack, "R4 data ack", ack, 1);
        exp_q.push_back({1'b1, 8'h3C});
        start_c(); wr_byte(8'hA5, "R4 addr bits", ack); chk(ack, "R5 R8 read ack after restart", ack, 1);
        rd_byte(8'hFF, 1'b0, got); chk(got == 8'h96, "R8 read byte", got, 8'h96);
        chk(drv == 1'b0, "R8 released after byte", drv, 0);
        stop_c(); wt(4);
        chk(exp_q.size() == 0, "R5 commit seen on restart", exp_q.size(), 0);

        // R6 partial byte then stop / then start
        sel = 1'b0;
        start_c(); wr_byte(8'hA0, "R4 addr bits", ack); part_bits(4); stop_c(); wt(4);
        chk(wbyte == 8'h3C, "R6 byte kept after partial+stop", wbyte, 8'h3C);
        start_c(); wr_byte(8'hA0, "R4 addr bits", ack); part_bits(5);
        // R7 alert write on the restart
        start_c(); wr_byte(8'h18, "R7 line untouched", ack); chk(!ack, "R7 alert write not acked", ack, 0);
        stop_c(); wt(4);
        chk(wbyte == 8'h3C, "R6 byte kept after partial+start", wbyte, 8'h3C);

        // R9 alert read, none pending
        start_c(); wr_byte(8'h19, "R9 line untouched", ack); chk(!ack, "R9 no ack without alert", ack, 0);
        stop_c();
        // R9 alert read pending, sel=0 -> A0
        alert = 1'b1;
        start_c(); wr_byte(8'h19, "R4 addr bits", ack); chk(ack, "R9 alert ack", ack, 1);
        rd_byte(8'hFF, 1'b0, got); chk(got == 8'hA0, "R9 own address sel0", got, 8'hA0);
        stop_c();
        // R10 loses against lower address 1001110
        start_c(); wr_byte(8'h19, "R4 addr bits", ack);
        rd_byte(8'h9C, 1'b0, got); chk(got == 8'h9C, "R10 lower address wins", got, 8'h9C);
        chk(drv == 1'b0, "R10 released after loss", drv, 0);
        stop_c();
        // R10 wins against higher address 1011000, sel=1 -> A4
        sel = 1'b1;
        start_c(); wr_byte(8'h19, "R4 addr bits", ack);
        rd_byte(8'hB0, 1'b0, got); chk(got == 8'hA4, "R10 R9 win sel1", got, 8'hA4);
        stop_c();
        // R10 after loss: quiet, next transfer works
        start_c(); wr_byte(8'hA4, "R4 addr bits", ack); chk(ack, "R1 fresh start after loss", ack, 1);
        wr_byte(8'h11, "R4 data bits", ack); exp_q.push_back({1'b0, 8'h11}); stop_c(); wt(4);
        chk(exp_q.size() == 0, "R5 final commit", exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule